// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is a synchronous master for a three-wire serial analog-to-digital converter: an active-low chip select, a serial clock it generates, and one serial data input. A conversion frame begins when chip select goes low. The controller then produces a fixed train of serial clock pulses and rebuilds the converter's result from the bits returned on the data line. The serial clock is derived from the system clock. Its half period, counted in system clocks, is a parameter.

The converter leaves its data line undriven for the first part of the frame. It then sends one zero, followed by the result, most significant bit first. It changes the line just after each falling edge of the serial clock. The controller therefore takes a bit at each rising edge, throws away the first two, and collects the result bits from the rest. When the last bit arrives, the parallel result is updated and a one-cycle valid strobe is raised.

A start pulse runs a single frame. When a continuous-mode input is high, each frame is followed, after the minimum chip-select-high interval, by another frame without any further start pulse. The parameters are checked during elaboration against the converter's allowed clock range and its minimum timing.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During reset and while idle, cs_n is 1, sclk is 1, busy is 0 and result_valid is 0. After reset, result is 0.
- R2: When start is high in an idle cycle, cs_n and busy are both driven high-to-low and low-to-high respectively at that clock edge. cs_n then stays low for exactly 37*HALF_CYC cycles.
- R3: Within a frame, sclk stays high for HALF_CYC cycles after cs_n falls. It then makes 18 periods, each HALF_CYC cycles low followed by HALF_CYC cycles high. So there are exactly 18 rising edges per frame.
- R4: After the 18th rising edge, sclk stays high and cs_n stays low for HALF_CYC more cycles before cs_n rises.
- R5: sdata is sampled at the clock edge at which sclk rises. The bits taken at rising edges 1 and 2 are discarded. The bit taken at rising edge n, for n from 3 to 18, becomes result[18-n]. So result[15] comes from edge 3 and result[0] comes from edge 18.
- R6: result_valid is high for exactly one cycle per frame, starting at the edge of the 18th rising sclk edge, while cs_n is still low. result holds its value between strobes.
- R7: After cs_n rises, it stays high for at least GAP_CYC cycles. busy stays high through those GAP_CYC cycles and falls when they end (unless a new frame starts).
- R8: A start pulse received while busy is high has no effect: no extra frame follows once the current frame and gap finish.
- R9: If cont is high at the end of the gap, a new frame begins at once with no start pulse. Frames then repeat every 37*HALF_CYC+GAP_CYC cycles. If cont is low at that point, the block goes idle.
- R10: Elaboration fails unless all of the following hold: CLK_HZ/(2*HALF_CYC) is between 1 MHz and 5 MHz; HALF_CYC covers at least 20 ns and 8 ns; GAP_CYC covers at least 20 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one frame when idle |
| cont | input | 1 | Continuous mode: chain frames automatically |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or post-frame gap in progress |
| result | output | RES_W | Last complete conversion result |
| result_valid | output | 1 | One-cycle strobe with a new result |

## Verification
The bench builds the block with HALF_CYC=10 and GAP_CYC=3 on a 100 MHz clock. This places the serial clock exactly at the 5 MHz upper limit, so the range check is exercised at its edge. It also keeps a 373-cycle frame short enough to run single frames, a start pulse that arrives mid-frame, and a chain of continuous frames within a small cycle budget. The short gap makes the gap-to-lead-in transition and the cont-low exit to idle visible within a few cycles of every frame end. Result words with all ones, all zeros, a lone MSB and a lone LSB test the bit alignment. The converter model drives the line high before the zero bit, so any bit taken from the two discarded edges would show up in the result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } seq_st_t;

  localparam int unsigned LEAD_BITS   = 2;
  localparam longint      SCLK_MIN_HZ = 64'd1_000_000;
  localparam longint      SCLK_MAX_HZ = 64'd5_000_000;
  localparam longint      MIN_LVL_NS  = 64'd20;
  localparam longint      MIN_CS_NS   = 64'd8;
  localparam longint      MIN_GAP_NS  = 64'd20;

  // Smallest whole number of system clocks covering ns nanoseconds.
  function automatic longint cycles_for_ns(longint clk_hz, longint ns);
    return (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

  // Serial clock frequency range, checked without division rounding.
  function automatic bit rate_ok(longint clk_hz, longint half);
    return (2 * half * SCLK_MAX_HZ >= clk_hz) && (2 * half * SCLK_MIN_HZ <= clk_hz);
  endfunction

  function automatic bit cfg_ok(longint clk_hz, longint half, longint gap);
    return rate_ok(clk_hz, half)
        && (half >= cycles_for_ns(clk_hz, MIN_LVL_NS))
        && (half >= cycles_for_ns(clk_hz, MIN_CS_NS))
        && (gap  >= cycles_for_ns(clk_hz, MIN_GAP_NS))
        && (gap  >= 1);
  endfunction

  // Cycles chip select is low in one frame: lead-in plus both phases of every clock.
  function automatic int unsigned frame_low_cycles(int unsigned half, int unsigned nclk);
    return half * (2 * nclk + 1);
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned HALF_CYC = 20,
  parameter int unsigned GAP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_gap,
  output logic phase_end
);
  localparam int unsigned MAXC = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit     = sel_gap ? GAP_LAST : HALF_LAST;
  assign phase_end = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || phase_end) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit)); // R3

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned FRAME_CLKS = 18,
  parameter int unsigned GAP_CYC    = 4,
  localparam int unsigned BW        = $clog2(FRAME_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cont,
  input  logic          phase_end,
  output logic          cs_n,
  output logic          sclk,
  output logic          busy,
  output logic          run,
  output logic          sel_gap,
  output logic          rise_evt,
  output logic [BW-1:0] rise_num
);
  localparam logic [BW-1:0] LAST_RISE = BW'(FRAME_CLKS);

  seq_st_t       st_q, st_d;
  logic [BW-1:0] nrise_q;
  logic          cs_n_q, sclk_q;

  assign run      = (st_q != ST_IDLE);
  assign sel_gap  = (st_q == ST_GAP);
  assign busy     = run;
  assign rise_evt = (st_q == ST_LOW) && phase_end;
  assign rise_num = nrise_q + 1'b1;
  assign cs_n     = cs_n_q;
  assign sclk     = sclk_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)     st_d = ST_LEAD;
      ST_LEAD: if (phase_end) st_d = ST_LOW;
      ST_LOW:  if (phase_end) st_d = ST_HIGH;
      ST_HIGH: if (phase_end) st_d = (nrise_q == LAST_RISE) ? ST_GAP : ST_LOW;
      ST_GAP:  if (phase_end) st_d = cont ? ST_LEAD : ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      nrise_q <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cs_n_q <= (st_d == ST_IDLE) || (st_d == ST_GAP);
      sclk_q <= (st_d != ST_LOW);
      if (st_d == ST_LEAD) nrise_q <= '0;
      else if (rise_evt)   nrise_q <= rise_num;
    end
  end

  // Observation-only: consecutive cycles with chip select high, saturating.
  logic [7:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_run_q <= 8'hFF;
    else if (!cs_n_q)        hi_run_q <= '0;
    else if (hi_run_q != 8'hFF) hi_run_q <= hi_run_q + 1'b1;
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R1
  AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (rise_num <= LAST_RISE)); // R3
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(sclk)); // R4
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_run_q >= 8'((GAP_CYC > 254) ? 254 : GAP_CYC))); // R7
  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R2

endmodule

// File: rtl/adc_rd_deser.sv
module adc_rd_deser #(
  parameter int unsigned RES_W     = 16,
  parameter int unsigned SKIP_BITS = 2,
  parameter int unsigned BW        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic [BW-1:0]    rise_num,
  input  logic             sdata,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);
  localparam logic [BW-1:0] FIRST_KEEP = BW'(SKIP_BITS + 1);
  localparam logic [BW-1:0] LAST_KEEP  = BW'(SKIP_BITS + RES_W);

  logic [RES_W-1:0] shreg_q;
  logic [RES_W-1:0] shreg_d;
  logic             keep_bit, last_bit;

  assign keep_bit = rise_evt && (rise_num >= FIRST_KEEP);
  assign last_bit = rise_evt && (rise_num == LAST_KEEP);
  assign shreg_d  = {shreg_q[RES_W-2:0], sdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q      <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= last_bit;
      if (keep_bit) shreg_q <= shreg_d;
      if (last_bit) result  <= shreg_d;
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result)); // R6
  AST_NO_EARLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && rise_num <= BW'(SKIP_BITS)) |=> $stable(shreg_q)); // R5

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned HALF_CYC = 20,
  parameter int unsigned GAP_CYC  = 4,
  parameter int unsigned RES_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);
  localparam int unsigned FRAME_CLKS = RES_W + LEAD_BITS;
  localparam int unsigned BW         = $clog2(FRAME_CLKS + 1);

  // R10: refuse configurations outside the converter's timing window.
  generate
    if (!cfg_ok(longint'(CLK_HZ), longint'(HALF_CYC), longint'(GAP_CYC))) begin : g_bad_cfg
      $error("adc_rd_ctrl: HALF_CYC/GAP_CYC out of range for CLK_HZ");
    end
  endgenerate

  logic          run, sel_gap, phase_end, rise_evt;
  logic [BW-1:0] rise_num;

  adc_rd_timer #(
    .HALF_CYC (HALF_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sel_gap   (sel_gap),
    .phase_end (phase_end)
  );

  adc_rd_seq #(
    .FRAME_CLKS (FRAME_CLKS),
    .GAP_CYC    (GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cont      (cont),
    .phase_end (phase_end),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .busy      (busy),
    .run       (run),
    .sel_gap   (sel_gap),
    .rise_evt  (rise_evt),
    .rise_num  (rise_num)
  );

  adc_rd_deser #(
    .RES_W     (RES_W),
    .SKIP_BITS (LEAD_BITS),
    .BW        (BW)
  ) u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_evt     (rise_evt),
    .rise_num     (rise_num),
    .sdata        (sdata),
    .result       (result),
    .result_valid (result_valid)
  );

  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (!cs_n && sclk)); // R6
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> $rose(sclk)); // R5

endmodule

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
  localparam int H    = 10;
  localparam int G    = 3;
  localparam int W    = 16;
  localparam int LOWT = H * 37;
  localparam int VALT = H * 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cont = 1'b0;
  logic sdata = 1'b1;
  logic cs_n, sclk, busy, result_valid;
  logic [W-1:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.CLK_HZ(100_000_000), .HALF_CYC(H), .GAP_CYC(G), .RES_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .result(result), .result_valid(result_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Words the converter will return, and the reference's own copy.
  logic [W-1:0] adc_q[$];
  logic [W-1:0] exp_q[$];

  // Converter model: reacts to the controller's pins.
  logic [W-1:0] adc_word = '0;
  int falls = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      adc_word = (adc_q.size() > 0) ? adc_q.pop_front() : '0;
      falls = 0;
      sdata = 1'b1;
    end
    if (!cs_n && prev_sclk && !sclk) begin
      falls++;
      if (falls == 2) sdata = 1'b0;
      else if (falls >= 3 && falls <= 18) sdata = adc_word[18 - falls];
    end
    if (cs_n) sdata = 1'b1;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  // Reference model: 0 idle, 1 frame (t), 2 gap (g).
  int mode = 0, t = 0, g = 0;
  logic [W-1:0] exp_word = '0, exp_res = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; t = 0; g = 0;
    end else begin
      case (mode)
        0: if (start) begin mode = 1; t = 0; exp_word = exp_q.pop_front(); end
        1: if (t == LOWT - 1) begin mode = 2; g = 0; end else t++;
        default: if (g == G - 1) begin
                   if (cont) begin mode = 1; t = 0; exp_word = exp_q.pop_front(); end
                   else mode = 0;
                 end else g++;
      endcase
    end
  end

  int n_valid = 0, last_valid = -1, period_seen = -1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      logic e_cs, e_sclk, e_busy, e_val;
      e_cs   = (mode != 1);
      e_sclk = (mode == 1 && t >= H) ? (((t - H) / H) % 2 != 0) : 1'b1;
      e_busy = (mode != 0);
      e_val  = (mode == 1 && t == VALT);
      chk(cs_n == e_cs, "R2 R4 cs_n", cs_n, e_cs);
      chk(sclk == e_sclk, "R3 sclk", sclk, e_sclk);
      chk(busy == e_busy, "R7 R8 busy", busy, e_busy);
      chk(result_valid == e_val, "R6 result_valid", result_valid, e_val);
      if (e_val) exp_res = exp_word;
      chk(result == exp_res, "R5 result", result, exp_res);
      if (result_valid) begin
        n_valid++;
        if (last_valid >= 0) period_seen = cyc - last_valid;
        last_valid = cyc;
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic one_frame(input logic [W-1:0] w);
    adc_q.push_back(w);
    exp_q.push_back(w);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    cycles(2);
  endtask

  initial begin
    cycles(3);
    // R1: levels during reset
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 reset pins", {cs_n, sclk}, 2'b11);
    chk(busy == 1'b0 && result_valid == 1'b0, "R1 reset flags", {busy, result_valid}, 0);
    rst_n = 1'b1;
    cycles(4);
    chk(result == '0, "R1 result after reset", result, 0);

    one_frame(16'hA5C3);
    one_frame(16'h8000); // R5 MSB alignment
    one_frame(16'h0001); // R5 LSB alignment
    one_frame(16'hFFFF);
    one_frame(16'h0000); // R5 leading ones on the line must be discarded
    chk(result == 16'h0000, "R5 zeros word", result, 0);

    // R8: start pulses mid-frame and during the gap are ignored
    adc_q.push_back(16'h1234); exp_q.push_back(16'h1234);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles(100); start = 1'b1; @(negedge clk); start = 1'b0;
    while (!cs_n) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    cycles(20);
    chk(cs_n == 1'b1 && busy == 1'b0, "R8 no extra frame", {cs_n, busy}, 2'b10);
    chk(result == 16'h1234, "R8 result kept", result, 16'h1234);

    // R9: continuous chain of four frames
    n_valid = 0; last_valid = -1; period_seen = -1;
    for (int i = 0; i < 4; i++) begin
      adc_q.push_back(16'h1111 * (i + 3)); exp_q.push_back(16'h1111 * (i + 3));
    end
    cont = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cycles(3 * (LOWT + G) + 10);
    cont = 1'b0;
    wait_idle();
    cycles(5);
    chk(n_valid == 4, "R9 frame count", n_valid, 4);
    chk(period_seen == LOWT + G, "R9 frame period", period_seen, LOWT + G);
    chk(result == 16'h6666, "R9 last word", result, 16'h6666);

    // R10: configured rate sits inside the converter's window
    chk((100_000_000 / (2 * H)) <= 5_000_000 && (100_000_000 / (2 * H)) >= 1_000_000,
        "R10 sclk rate", 100_000_000 / (2 * H), 5_000_000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule